// File: doc/BRIEF.md
# Stop-Wake Clock Source Switcher

This block picks the clock that drives the system after the device wakes from a low-power stop state. Two clock inputs reach it: a ring oscillator that starts fast but has a loose frequency, and an external crystal clock that is precise but needs time to settle. A stop request gates the system clock off. A wake event starts a settling count of external-clock cycles. A software select input decides what runs during that count. When it is set, the system resumes on the ring oscillator almost at once. When it is clear, the system clock stays gated until the count ends.

When the count ends, the block hands the system clock over to the external source. The handover is glitch-free: each source has its own enable. That enable is synchronised in its own clock domain, and it only turns on after the other source's enable is seen off. A status output reports ring operation. A peripheral-enable output holds timing-critical peripherals off until that status has cleared. The control state machine and the settling counter run in the external-clock domain.

Top module: `stopwake_clk_switch`

## Requirements
- R1: After reset the system clock follows the external clock. `ring_mode` is 0, and `periph_en` rises within a few external-clock cycles.
- R2: A one-cycle `stop_req` pulse while running gates `sys_clk` off. No edges appear until a wake, and `ring_mode` and `periph_en` are both 0.
- R3: A `wake` pulse while stopped, with `ring_sel` = 1, restarts `sys_clk` from the ring clock within a few ring-clock cycles. `ring_mode` is 1 from the next external-clock edge.
- R4: The settling count runs on external-clock edges only, for `STAB_CYCLES` cycles (default 65536), and it restarts from zero on every wake.
- R5: Once the count completes, the ring enable drops and the external enable rises. `ring_mode` clears only once the external enable is on.
- R6: A `wake` pulse while stopped, with `ring_sel` = 0, leaves `sys_clk` gated for the whole count. It then releases `sys_clk` on the external clock, and `ring_mode` stays 0 throughout.
- R7: `periph_en` is 0 whenever `ring_mode` is 1, while stopped, and during the count. It rises one cycle after `ring_mode` clears with the external clock enabled.
- R8: The two source enables are never on together, and `sys_clk` never shows a high or low pulse shorter than half the faster source period.
- R9: A `stop_req` during the settling count aborts the count, gates `sys_clk` off and clears `ring_mode`. The next wake needs a full new count.
- R10: `wake` while running on the external clock has no effect. `sys_clk` keeps running, `ring_mode` stays 0 and `periph_en` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ring_clk | input | 1 | Fast-start, imprecise internal clock |
| ext_clk | input | 1 | Precise external crystal clock; clocks the control logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | One-cycle pulse requesting stop (ext_clk domain) |
| wake | input | 1 | One-cycle wake-up event (ext_clk domain) |
| ring_sel | input | 1 | 1: resume on ring clock at wake; 0: wait for the external clock |
| sys_clk | output | 1 | Gated, glitch-free system clock |
| ring_mode | output | 1 | 1 while the system runs from the ring clock |
| periph_en | output | 1 | Enable for timing-critical peripherals |

## Verification
The assertions check on every cycle that the two source enables never overlap, and that `periph_en` is never high alongside `ring_mode`. They also check that a wake picks the state that matches `ring_sel`, that a stop during the count lands in the stopped state, and that `ring_mode` only falls once the external enable is on or the block has stopped. Only the bench scenarios can show the rest. That covers the real timing of the count in external-clock cycles and the restart of the count after an abort. It also covers the absence of `sys_clk` edges while gated and the measured pulse widths on `sys_clk` across each handover.

// File: rtl/clkswt_pkg.sv
`timescale 1ns/1ps
package clkswt_pkg;
  typedef enum logic [1:0] {
    ST_RUN_EXT = 2'd0,
    ST_STOPPED = 2'd1,
    ST_RING    = 2'd2,
    ST_EXTWAIT = 2'd3
  } sw_state_t;
endpackage

// File: rtl/clkswt_sync.sv
`timescale 1ns/1ps
module clkswt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkswt_gate.sv
`timescale 1ns/1ps
module clkswt_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic other_on,
  output logic on
);
  logic want_s;
  logic other_s;

  clkswt_sync #(.STAGES(SYNC_STAGES)) u_want (
    .clk(clk), .rst_n(rst_n), .d(want), .q(want_s)
  );

  clkswt_sync #(.STAGES(SYNC_STAGES)) u_other (
    .clk(clk), .rst_n(rst_n), .d(other_on), .q(other_s)
  );

  // Enable changes only while this clock is low, so no pulse is cut.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) on <= 1'b0;
    else        on <= want_s & ~other_s;
  end
endmodule

// File: rtl/clkswt_ctrl.sv
`timescale 1ns/1ps
module clkswt_ctrl
  import clkswt_pkg::*;
#(
  parameter int STAB_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic wake,
  input  logic ring_sel,
  input  logic ext_on,
  output logic want_ring,
  output logic want_ext,
  output logic ring_mode,
  output logic periph_en
);
  localparam int CW = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

  sw_state_t state, nstate;
  logic [CW-1:0] cnt;
  logic counting;
  logic done;

  assign counting = (state == ST_RING) || (state == ST_EXTWAIT);
  assign done     = counting && (cnt == LAST);

  always_comb begin
    nstate = state;
    case (state)
      ST_RUN_EXT: if (stop_req) nstate = ST_STOPPED;
      ST_STOPPED: if (wake) nstate = ring_sel ? ST_RING : ST_EXTWAIT;
      ST_RING, ST_EXTWAIT: begin
        if (stop_req)  nstate = ST_STOPPED;
        else if (done) nstate = ST_RUN_EXT;
      end
      default: nstate = ST_STOPPED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN_EXT;
      cnt       <= '0;
      ring_mode <= 1'b0;
      periph_en <= 1'b0;
    end else begin
      state     <= nstate;
      cnt       <= (counting && nstate == state) ? cnt + 1'b1 : '0;
      ring_mode <= (nstate == ST_RING) ||
                   (ring_mode && nstate == ST_RUN_EXT && !ext_on);
      periph_en <= (state == ST_RUN_EXT) && ext_on && !ring_mode;
    end
  end

  assign want_ring = (state == ST_RING);
  assign want_ext  = (state == ST_RUN_EXT);

  p_periph_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ring_mode |-> !periph_en);

  p_abort_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && stop_req) |=> (state == ST_STOPPED && !ring_mode));

  p_wake_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOPPED && wake && ring_sel) |=> (state == ST_RING && ring_mode));

  p_wake_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOPPED && wake && !ring_sel) |=> (state == ST_EXTWAIT && !ring_mode));

  p_clear_on_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ring_mode) |-> ((state == ST_RUN_EXT && ext_on) || state == ST_STOPPED));

  p_wake_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN_EXT && !stop_req) |=> (state == ST_RUN_EXT));
endmodule

// File: rtl/stopwake_clk_switch.sv
`timescale 1ns/1ps
module stopwake_clk_switch #(
  parameter int STAB_CYCLES = 65536,
  parameter int SYNC_STAGES = 2
) (
  input  logic ring_clk,
  input  logic ext_clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic wake,
  input  logic ring_sel,
  output logic sys_clk,
  output logic ring_mode,
  output logic periph_en
);
  logic want_ring, want_ext;
  logic ring_on, ext_on;

  clkswt_ctrl #(.STAB_CYCLES(STAB_CYCLES)) u_ctrl (
    .clk(ext_clk), .rst_n(rst_n), .stop_req(stop_req), .wake(wake),
    .ring_sel(ring_sel), .ext_on(ext_on), .want_ring(want_ring),
    .want_ext(want_ext), .ring_mode(ring_mode), .periph_en(periph_en)
  );

  clkswt_gate #(.SYNC_STAGES(SYNC_STAGES)) u_ring_gate (
    .clk(ring_clk), .rst_n(rst_n), .want(want_ring),
    .other_on(ext_on), .on(ring_on)
  );

  clkswt_gate #(.SYNC_STAGES(SYNC_STAGES)) u_ext_gate (
    .clk(ext_clk), .rst_n(rst_n), .want(want_ext),
    .other_on(ring_on), .on(ext_on)
  );

  assign sys_clk = (ring_clk & ring_on) | (ext_clk & ext_on);

  p_gates_exclusive_ext_r8: assert property (@(posedge ext_clk) disable iff (!rst_n)
    !(ring_on && ext_on));

  p_gates_exclusive_ring_r8: assert property (@(posedge ring_clk) disable iff (!rst_n)
    !(ring_on && ext_on));
endmodule

// File: tb/tb_stopwake_clk_switch.sv
`timescale 1ns/1ps
module tb_stopwake_clk_switch;
  localparam real CLK_PERIOD  = 10.0;
  localparam real RING_PERIOD = 7.3;
  localparam int  STAB        = 64;
  localparam real MIN_PULSE   = 3.0;

  logic ring_clk = 1'b0, ext_clk = 1'b0, rst_n = 1'b0;
  logic stop_req = 1'b0, wake = 1'b0, ring_sel = 1'b0;
  logic sys_clk, ring_mode, periph_en;

  int errors = 0, checks = 0, glitches = 0, sys_edges = 0;
  bit finished = 1'b0;

  typedef struct { string tag; bit rm; bit pe; bit act; } exp_t;
  exp_t exp_q[$];
  event chk_ev, done_ev;

  stopwake_clk_switch #(.STAB_CYCLES(STAB)) dut (
    .ring_clk(ring_clk), .ext_clk(ext_clk), .rst_n(rst_n),
    .stop_req(stop_req), .wake(wake), .ring_sel(ring_sel),
    .sys_clk(sys_clk), .ring_mode(ring_mode), .periph_en(periph_en)
  );

  always #(CLK_PERIOD/2.0)  ext_clk  = ~ext_clk;
  always #(RING_PERIOD/2.0) ring_clk = ~ring_clk;

  // Pulse-width monitor on the system clock (R8)
  realtime last_edge = 0.0;
  always @(sys_clk) begin
    if (rst_n && last_edge > 0.0 && ($realtime - last_edge) < MIN_PULSE)
      glitches++;
    last_edge = $realtime;
    if (sys_clk) sys_edges++;
  end

  task automatic compare(string tag, string what, bit act_v, bit exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act_v, exp_v);
    end
  endtask

  // Monitor: pops expected item, observes a window of sys_clk, compares
  initial begin
    forever begin
      exp_t e;
      int n0;
      @chk_ev;
      e = exp_q.pop_front();
      n0 = sys_edges;
      repeat (6) @(negedge ext_clk);
      compare(e.tag, "sys_clk active", sys_edges != n0, e.act);
      compare(e.tag, "ring_mode", ring_mode, e.rm);
      compare(e.tag, "periph_en", periph_en, e.pe);
      ->done_ev;
    end
  end

  task automatic expect_state(string tag, bit rm, bit pe, bit act);
    exp_t e;
    e.tag = tag; e.rm = rm; e.pe = pe; e.act = act;
    exp_q.push_back(e);
    ->chk_ev;
    @done_ev;
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge ext_clk);
  endtask

  task automatic pulse_stop();
    stop_req = 1'b1; cycles(1); stop_req = 1'b0;
  endtask

  task automatic pulse_wake(bit sel);
    ring_sel = sel; wake = 1'b1; cycles(1); wake = 1'b0;
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    // R1: reset state and running on external clock
    cycles(4);
    expect_state("R1", 1'b0, 1'b1, 1'b1);

    // R10: wake while running is ignored
    pulse_wake(1'b1);
    expect_state("R10", 1'b0, 1'b1, 1'b1);

    // R2: stop gates the clock
    pulse_stop();
    cycles(5);
    expect_state("R2", 1'b0, 1'b0, 1'b0);

    // R3/R4: wake on ring clock, still counting
    pulse_wake(1'b1);
    expect_state("R3", 1'b1, 1'b0, 1'b1);
    cycles(30);
    expect_state("R4", 1'b1, 1'b0, 1'b1);
    // R5/R7: after the count the switch completes
    cycles(30);
    expect_state("R5", 1'b0, 1'b1, 1'b1);

    // R6: wake without ring clock stays gated for the count
    pulse_stop();
    cycles(5);
    pulse_wake(1'b0);
    cycles(4);
    expect_state("R6", 1'b0, 1'b0, 1'b0);
    cycles(40);
    expect_state("R7", 1'b0, 1'b0, 1'b0);
    cycles(20);
    expect_state("R6", 1'b0, 1'b1, 1'b1);

    // R9: abort during ring count, then full new count needed
    pulse_stop();
    cycles(5);
    pulse_wake(1'b1);
    cycles(43);
    pulse_stop();
    cycles(5);
    expect_state("R9", 1'b0, 1'b0, 1'b0);
    pulse_wake(1'b0);
    cycles(24);
    expect_state("R9", 1'b0, 1'b0, 1'b0);
    cycles(40);
    expect_state("R4", 1'b0, 1'b1, 1'b1);

    // R8: no short pulses over all handovers
    checks++;
    if (glitches != 0) begin
      errors++;
      $display("FAIL R8 short pulses on sys_clk: actual=%0d expected=0", glitches);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000.0);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule